// File: doc/BRIEF.md
# Accelerator Job Configuration Register File

This block is the slave-side register file that a host uses to describe and launch one job on a matrix-operation engine. The host uses a 32-bit word bus with an address, a write enable, four byte strobes, write data and read data. Through it the host loads three tensor base pointers, the three matrix dimensions and an arithmetic control word. The block holds these values in registers and presents them to the engine as decoded fields: pointers, sizes, operation select, data format and a custom-format flag.

When the host writes the launch word, the block sends the engine a one-cycle start pulse and raises a busy flag. Busy stays high until the engine returns a done pulse. While busy is high, the job description is frozen and cannot be changed. A write to the soft-clear word returns every register and the busy flag to zero. A status word lets the host poll busy.

The block decodes word addresses, so address bits [1:0] are ignored. Read data is registered. It appears one cycle after the address is presented and shows the register contents from before any write in that same cycle.

Top module: `job_cfg_regfile`

## Requirements
- R1: After reset, every configuration register, every field output, `busy`, `job_start` and `bus_rdata` are zero.
- R2: Words at offsets 0x40, 0x44 and 0x48 hold the X, W and Z pointers as full 32-bit values. A write updates only the bytes whose strobe bit is set (strobe bit b covers data bits [8b+7:8b]).
- R3: The word at 0x4C carries the M size in bits [15:0] and the K size in bits [31:16]. These appear on `m_size` and `k_size`.
- R4: The word at 0x50 is the 32-bit N size and appears on `n_size`.
- R5: The word at 0x54 carries the custom-format flag in bit 14, the operation select in bits [12:10] and the data format in bits [9:7]. All other bits of this word are discarded on write and read as zero (the kept mask is 0x00005F80).
- R6: A write to offset 0x00 while idle, with any data and any strobes, produces `job_start` high for exactly one cycle, starting in the cycle after the write. `busy` becomes 1 in that same cycle.
- R7: `engine_done` high while busy clears `busy` in the next cycle. While idle it has no effect.
- R8: While busy, writes to the configuration words and to the launch word are ignored: no register changes and no start pulse.
- R9: A write to offset 0x14, busy or not, sets all configuration registers, `busy` and `job_start` to zero in the next cycle.
- R10: A read of offset 0x0C returns `busy` in bit 0 and zero in bits [31:1]. Writes to it have no effect.
- R11: Reads of any offset other than 0x0C and 0x40 to 0x54 return zero. Writes to unmapped offsets change nothing.
- R12: `bus_rdata` is the contents of the word addressed in the previous cycle, taken from before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| engine_done | input | 1 | Pulse from the engine at the end of a job |
| busy | output | 1 | A job is running |
| job_start | output | 1 | One-cycle launch pulse to the engine |
| x_ptr | output | 32 | X tensor pointer |
| w_ptr | output | 32 | W tensor pointer |
| z_ptr | output | 32 | Z tensor pointer |
| m_size | output | 16 | M dimension |
| k_size | output | 16 | K dimension |
| n_size | output | 32 | N dimension |
| op_sel | output | 3 | Operation select |
| fmt_sel | output | 3 | Input/output data format |
| cust_fmt | output | 1 | Custom-format enable |

## Verification
The bench writes all-ones, all-zeros, alternating-bit and walking-one patterns to every configuration word. This separates correct storage from stuck bits, swapped words and a wrong mask on the arithmetic word. It writes all sixteen strobe combinations over a known base value, which shows whether each strobe reaches its own byte lane. It sweeps every combination of operation, format and custom flag with junk in the unused bits. That sweep checks the field positions and the discarding of the unused bits together. It also sweeps every word address of the space for zero reads and harmless writes, and runs launch, done, clear and read-during-write sequences. These sequences separate the busy gating, pulse length, clear priority and read timing from plain storage.

// File: rtl/job_cfg_pkg.sv
package job_cfg_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTES   = WORD_W / 8;
  localparam int NUM_CFG = 6;

  // word indices (byte offset / 4)
  localparam int TRIG_WORD     = 0;
  localparam int STAT_WORD     = 3;
  localparam int CLR_WORD      = 5;
  localparam int CFG_BASE_WORD = 16;

  // configuration slots, ascending offset from CFG_BASE_WORD
  localparam int IDX_XPTR  = 0;
  localparam int IDX_WPTR  = 1;
  localparam int IDX_ZPTR  = 2;
  localparam int IDX_KM    = 3;
  localparam int IDX_N     = 4;
  localparam int IDX_ARITH = 5;

  // arithmetic word layout
  localparam int CUST_BIT = 14;
  localparam int OP_LSB   = 10;
  localparam int FMT_LSB  = 7;
  localparam int SEL_W    = 3;
  localparam int HALF_W   = WORD_W / 2;

  localparam logic [WORD_W-1:0] ARITH_KEEP =
    (WORD_W'(1) << CUST_BIT) |
    (WORD_W'((1 << SEL_W) - 1) << OP_LSB) |
    (WORD_W'((1 << SEL_W) - 1) << FMT_LSB);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_TRIG,
    SEL_STAT,
    SEL_CLR
  } sel_e;

  function automatic logic [WORD_W-1:0] slot_keep(input int idx);
    return (idx == IDX_ARITH) ? ARITH_KEEP : {WORD_W{1'b1}};
  endfunction

endpackage

// File: rtl/job_cfg_decode.sv
module job_cfg_decode
  import job_cfg_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int IDX_W   = 3
) (
  input  logic [WORD_AW-1:0] word,
  output sel_e               sel,
  output logic [IDX_W-1:0]   idx
);

  localparam logic [WORD_AW-1:0] CFG_LO = WORD_AW'(CFG_BASE_WORD);
  localparam logic [WORD_AW-1:0] CFG_HI = WORD_AW'(CFG_BASE_WORD + NUM_CFG);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (word == WORD_AW'(TRIG_WORD)) begin
      sel = SEL_TRIG;
    end else if (word == WORD_AW'(STAT_WORD)) begin
      sel = SEL_STAT;
    end else if (word == WORD_AW'(CLR_WORD)) begin
      sel = SEL_CLR;
    end else if (word >= CFG_LO && word < CFG_HI) begin
      sel = SEL_CFG;
      idx = IDX_W'(word - CFG_LO);
    end
  end

endmodule

// File: rtl/job_cfg_store.sv
module job_cfg_store
  import job_cfg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [BYTES-1:0]                wr_be,
  input  logic [WORD_W-1:0]               wr_data,
  output logic [NUM_CFG-1:0][WORD_W-1:0]  cfg_q
);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
    localparam logic [WORD_W-1:0] KEEP = slot_keep(g);
    logic [WORD_W-1:0] merged;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : cfg_q[g][b*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cfg_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        cfg_q[g] <= merged & KEEP;
      end
    end
  end

endmodule

// File: rtl/job_cfg_ctrl.sv
module job_cfg_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  input  logic done,
  output logic busy,
  output logic start
);

  logic launch;
  assign launch = trig && !busy;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= launch;
      if (launch) begin
        busy <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/job_cfg_regfile.sv
module job_cfg_regfile
  import job_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              engine_done,
  output logic              busy,
  output logic              job_start,
  output logic [31:0]       x_ptr,
  output logic [31:0]       w_ptr,
  output logic [31:0]       z_ptr,
  output logic [15:0]       m_size,
  output logic [15:0]       k_size,
  output logic [31:0]       n_size,
  output logic [2:0]        op_sel,
  output logic [2:0]        fmt_sel,
  output logic              cust_fmt
);

  localparam int WORD_AW = ADDR_W - 2;
  localparam int IDX_W   = $clog2(NUM_CFG);

  logic [1:0]                     addr_lsb_unused;
  sel_e                           sel;
  logic [IDX_W-1:0]               idx;
  logic                           cfg_wr;
  logic                           trig_wr;
  logic                           clr_wr;
  logic [NUM_CFG-1:0][WORD_W-1:0] cfg_q;
  logic [WORD_W-1:0]              rdata_d;

  assign addr_lsb_unused = bus_addr[1:0];

  job_cfg_decode #(
    .WORD_AW (WORD_AW),
    .IDX_W   (IDX_W)
  ) u_decode (
    .word (bus_addr[ADDR_W-1:2]),
    .sel  (sel),
    .idx  (idx)
  );

  assign cfg_wr  = bus_we && (sel == SEL_CFG) && !busy;
  assign trig_wr = bus_we && (sel == SEL_TRIG);
  assign clr_wr  = bus_we && (sel == SEL_CLR);

  job_cfg_store #(
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_wr),
    .wr_en   (cfg_wr),
    .wr_idx  (idx),
    .wr_be   (bus_be),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q)
  );

  job_cfg_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_wr),
    .trig  (trig_wr),
    .done  (engine_done),
    .busy  (busy),
    .start (job_start)
  );

  always_comb begin
    case (sel)
      SEL_CFG:  rdata_d = cfg_q[idx];
      SEL_STAT: rdata_d = {{(WORD_W-1){1'b0}}, busy};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rdata_d;
    end
  end

  assign x_ptr    = cfg_q[IDX_XPTR];
  assign w_ptr    = cfg_q[IDX_WPTR];
  assign z_ptr    = cfg_q[IDX_ZPTR];
  assign m_size   = cfg_q[IDX_KM][HALF_W-1:0];
  assign k_size   = cfg_q[IDX_KM][WORD_W-1:HALF_W];
  assign n_size   = cfg_q[IDX_N];
  assign cust_fmt = cfg_q[IDX_ARITH][CUST_BIT];
  assign op_sel   = cfg_q[IDX_ARITH][OP_LSB +: SEL_W];
  assign fmt_sel  = cfg_q[IDX_ARITH][FMT_LSB +: SEL_W];

endmodule

// File: rtl/job_cfg_checker.sv
module job_cfg_checker
  import job_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-3:0] word_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              engine_done,
  input logic              busy,
  input logic              job_start,
  input logic [31:0]       x_ptr,
  input logic [31:0]       w_ptr,
  input logic [31:0]       z_ptr,
  input logic [15:0]       m_size,
  input logic [15:0]       k_size,
  input logic [31:0]       n_size,
  input logic [2:0]        op_sel,
  input logic [2:0]        fmt_sel,
  input logic              cust_fmt
);

  localparam int WA = ADDR_W - 2;

  logic clr_hit;
  logic trig_hit;
  logic arith_rd;
  logic stat_rd;
  logic zero_rd;

  assign clr_hit  = bus_we && word_addr == WA'(CLR_WORD);
  assign trig_hit = bus_we && word_addr == WA'(TRIG_WORD);
  assign arith_rd = word_addr == WA'(CFG_BASE_WORD + IDX_ARITH);
  assign stat_rd  = word_addr == WA'(STAT_WORD);
  assign zero_rd  = !stat_rd &&
                    !(word_addr >= WA'(CFG_BASE_WORD) && word_addr < WA'(CFG_BASE_WORD + NUM_CFG));

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !job_start && x_ptr == '0 && n_size == '0)); // R1

  AST_ARITH_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    arith_rd |=> ((bus_rdata & ~ARITH_KEEP) == '0)); // R5

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start); // R6

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    job_start |-> busy); // R6

  AST_START_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    !trig_hit |=> !job_start); // R6

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && engine_done && !clr_hit) |=> !busy); // R7

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr_hit) |=> ($stable(x_ptr) && $stable(w_ptr) && $stable(z_ptr) &&
                            $stable(m_size) && $stable(k_size) && $stable(n_size) &&
                            $stable(op_sel) && $stable(fmt_sel) && $stable(cust_fmt))); // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (!busy && !job_start && x_ptr == '0 && w_ptr == '0 && z_ptr == '0 &&
                 m_size == '0 && k_size == '0 && n_size == '0 &&
                 op_sel == '0 && fmt_sel == '0 && !cust_fmt)); // R9

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (bus_rdata == {31'b0, $past(busy)})); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    zero_rd |=> (bus_rdata == '0)); // R11

endmodule

bind job_cfg_regfile job_cfg_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .word_addr   (bus_addr[ADDR_W-1:2]),
  .bus_we      (bus_we),
  .bus_rdata   (bus_rdata),
  .engine_done (engine_done),
  .busy        (busy),
  .job_start   (job_start),
  .x_ptr       (x_ptr),
  .w_ptr       (w_ptr),
  .z_ptr       (z_ptr),
  .m_size      (m_size),
  .k_size      (k_size),
  .n_size      (n_size),
  .op_sel      (op_sel),
  .fmt_sel     (fmt_sel),
  .cust_fmt    (cust_fmt)
);

// File: tb/tb_job_cfg_regfile.sv
module tb_job_cfg_regfile;

  localparam int ADDR_W = 8;
  localparam logic [31:0] KEEP54 = 32'h0000_5F80;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              engine_done = 1'b0;
  logic              busy, job_start;
  logic [31:0]       x_ptr, w_ptr, z_ptr, n_size;
  logic [15:0]       m_size, k_size;
  logic [2:0]        op_sel, fmt_sel;
  logic              cust_fmt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  job_cfg_regfile #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .engine_done(engine_done),
    .busy(busy), .job_start(job_start), .x_ptr(x_ptr), .w_ptr(w_ptr), .z_ptr(z_ptr),
    .m_size(m_size), .k_size(k_size), .n_size(n_size), .op_sel(op_sel),
    .fmt_sel(fmt_sel), .cust_fmt(cust_fmt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] keep_for(input int slot);
    return (slot == 5) ? KEEP54 : 32'hFFFF_FFFF;
  endfunction

  task automatic clear_all();
    wr(8'h14, 32'h0, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h5A5A_A5A5; pats[4] = 32'h0000_8001; pats[5] = 32'h1357_9BDF;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 job_start", {31'b0, job_start}, 0);
    check("R1 rdata", bus_rdata, 0);
    for (int s = 0; s < 6; s++) begin
      rd(8'(8'h40 + 4*s), r);
      check("R1 cfg word", r, 0);
    end
    check("R1 fields", x_ptr | w_ptr | z_ptr | n_size | {m_size, k_size} |
          {25'b0, cust_fmt, op_sel, fmt_sel}, 0);

    // R2 R4 R5 pattern sweep over all config words
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 6; p++) begin
        wr(8'(8'h40 + 4*s), pats[p], 4'hF);
        rd(8'(8'h40 + 4*s), r);
        check("R2/R4/R5 readback", r, pats[p] & keep_for(s));
      end
    end

    // R2 pointer outputs
    wr(8'h40, 32'h1000_0040, 4'hF);
    wr(8'h44, 32'h2000_0044, 4'hF);
    wr(8'h48, 32'h3000_0048, 4'hF);
    check("R2 x_ptr", x_ptr, 32'h1000_0040);
    check("R2 w_ptr", w_ptr, 32'h2000_0044);
    check("R2 z_ptr", z_ptr, 32'h3000_0048);

    // R2 byte strobe sweep
    for (int be = 0; be < 16; be++) begin
      logic [31:0] exp;
      wr(8'h44, 32'h1122_3344, 4'hF);
      wr(8'h44, 32'hAABB_CCDD, 4'(be));
      exp = 32'h1122_3344;
      for (int b = 0; b < 4; b++)
        if (be[b]) exp[b*8 +: 8] = 8'hAA + 8'(8'h11 * (3 - b));
      check("R2 strobe merge", w_ptr, exp);
    end

    // R3 K and M sizes
    for (int i = 0; i < 5; i++) begin
      logic [15:0] k, m;
      k = 16'(16'h0101 * i + 16'h0003);
      m = 16'(16'hFFFF - 16'h0700 * i);
      wr(8'h4C, {k, m}, 4'hF);
      check("R3 k_size", {16'b0, k_size}, {16'b0, k});
      check("R3 m_size", {16'b0, m_size}, {16'b0, m});
    end

    // R4 N size
    wr(8'h50, 32'hDEAD_0123, 4'hF);
    check("R4 n_size", n_size, 32'hDEAD_0123);

    // R5 arithmetic field sweep with junk bits
    for (int c = 0; c < 2; c++) begin
      for (int op = 0; op < 8; op++) begin
        for (int f = 0; f < 8; f++) begin
          logic [31:0] d;
          d = (32'(c) << 14) | (32'(op) << 10) | (32'(f) << 7) | 32'hFFFF_A07F;
          wr(8'h54, d, 4'hF);
          rd(8'h54, r);
          check("R5 arith readback", r, d & KEEP54);
          check("R5 fields", {25'b0, cust_fmt, op_sel, fmt_sel},
                32'(c * 64 + op * 8 + f));
        end
      end
    end

    // R11 unmapped sweep: read zero, writes harmless
    clear_all();
    wr(8'h40, 32'hCAFE_F00D, 4'hF);
    for (int w = 0; w < 64; w++) begin
      if (w == 3 || (w >= 16 && w <= 21)) continue;
      rd(8'(4*w), r);
      check("R11 unmapped read", r, 0);
      if (w != 0 && w != 5) wr(8'(4*w), 32'hFFFF_FFFF, 4'hF);
    end
    check("R11 no side effect x", x_ptr, 32'hCAFE_F00D);
    check("R11 no side effect busy", {31'b0, busy}, 0);

    // R10 status idle, write ignored
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h0C, r);
    check("R10 status idle", r, 0);

    // R6 launch
    wr(8'h00, 32'h0, 4'h0);
    check("R6 start pulse", {31'b0, job_start}, 1);
    check("R6 busy set", {31'b0, busy}, 1);
    @(negedge clk);
    check("R6 pulse width", {31'b0, job_start}, 0);
    rd(8'h0C, r);
    check("R10 status busy", r, 1);

    // R8 writes and relaunch ignored while busy
    wr(8'h40, 32'h1234_5678, 4'hF);
    wr(8'h54, 32'hFFFF_FFFF, 4'hF);
    check("R8 x frozen", x_ptr, 32'hCAFE_F00D);
    check("R8 arith frozen", {25'b0, cust_fmt, op_sel, fmt_sel}, 0);
    wr(8'h00, 32'h1, 4'hF);
    check("R8 no relaunch", {31'b0, job_start}, 0);

    // R7 done clears busy
    engine_done = 1'b1;
    @(negedge clk);
    engine_done = 1'b0;
    check("R7 busy cleared", {31'b0, busy}, 0);
    engine_done = 1'b1;
    @(negedge clk);
    engine_done = 1'b0;
    check("R7 done while idle", {30'b0, job_start, busy}, 0);
    wr(8'h40, 32'h1234_5678, 4'hF);
    check("R8 writable again", x_ptr, 32'h1234_5678);

    // R9 soft clear while busy
    wr(8'h4C, 32'h0040_0060, 4'hF);
    wr(8'h54, 32'h0000_4480, 4'hF);
    wr(8'h00, 32'h0, 4'h0);
    check("R9 pre busy", {31'b0, busy}, 1);
    wr(8'h14, 32'hABCD, 4'h1);
    check("R9 busy zero", {31'b0, busy}, 0);
    check("R9 start zero", {31'b0, job_start}, 0);
    check("R9 fields zero", x_ptr | w_ptr | z_ptr | n_size | {m_size, k_size} |
          {25'b0, cust_fmt, op_sel, fmt_sel}, 0);

    // R12 read during write returns old value
    wr(8'h48, 32'h0BAD_0001, 4'hF);
    bus_addr = 8'h48; bus_wdata = 32'h600D_0002; bus_be = 4'hF; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R12 old value", bus_rdata, 32'h0BAD_0001);
    @(negedge clk);
    check("R12 new value", bus_rdata, 32'h600D_0002);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule